// File: doc/BRIEF.md
# Receive Serial Frame Sync and Slot Timer

This block holds the receive-side serial frame timing for a single T1 or E1 channel. It runs on the serial clock and keeps one frame position counter. From that counter it decodes the time-slot index, the bit index inside the slot, a strobe for the first bit of the frame, and a flag for the T1 framing bit. When T1 data is carried in a 32-slot high-speed backplane frame, it also raises a don't-care flag on each unused slot.

The block has two roles. In the base-rate modes, with the generate request set, it acts as the timing source and emits a one-clock sync pulse on the first bit of every frame. In every other case it follows an external sync input. The pulse shape it expects depends on the backplane mode: a single clock on the first bit, a four-clock pulse across the frame boundary, or a two-clock pulse across the boundary. The rising edge of that input realigns the counter in the same cycle. Any pulse that is out of place or has the wrong width raises an error flag for one cycle.

The mode, the generate request and the T1 mapping select are static settings. A change to any of them is applied under reset.

Top module: `tdm_rx_frame_timer`

## Requirements
- R1: While reset is low, the outputs read slot 0, bit 0, first_bit 1, sync_out 0 and sync_err 0. The first clock after reset is released is frame position 0.
- R2: The frame length in clocks is set by mode (0:193, 1:256, 2:256, 3:512, 4:1024, 5:2048, 6:2048, 7:1024). The position counts up by one per clock and wraps to 0 after length-1. first_bit is high exactly at position 0.
- R3: The block drives the sync (sync_drive=1) only when gen_req=1 and mode is 0 or 1. It then pulses sync_out for one clock at position 0 of every frame. In all other cases sync_drive=0 and sync_out=0, so gen_req has no effect in modes 2 to 7.
- R4: In mode 0, position 0 is the framing bit (frm_bit=1, slot 0, bit 0). Position p≥1 gives slot (p-1)/8 and bit (p-1)%8.
- R5: In modes 1 to 7, with c = length/256 clocks per bit, position p gives bit (p/c)%8 and slot p/(8c). frm_bit stays 0.
- R6: dont_care is high only when t1_map=1, mode is 2 to 7 and the slot index is a multiple of 4 (slots 0,4,…,28). It is never high in modes 0 and 1.
- R7: In follower role with a single-clock mode (0 to 5), a rising edge of sync_in marks position 0 in that same clock.
- R8: In mode 6 a rising edge of sync_in marks position length-2, and the pulse is expected at length-2, length-1, 0 and 1. In mode 7 a rising edge marks length-1, and the pulse is expected at length-1 and 0.
- R9: sync_err stays 0 until the first rising edge of sync_in after reset. After that edge, sync_err is high for one clock in each clock where a rising edge lands at a counter position other than the one it marks, or where sync_in differs from the pattern expected at the current position.
- R10: After a misplaced rising edge the counter continues from the marked position. With sync_in held low, the counter runs free from its last alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Backplane mode, encoded as in R2 |
| gen_req | input | 1 | Request to act as sync source (honoured in modes 0 and 1) |
| t1_map | input | 1 | T1 payload carried in a 32-slot frame |
| sync_in | input | 1 | External frame sync, synchronous to clk, low when undriven |
| sync_out | output | 1 | Generated frame sync pulse |
| sync_drive | output | 1 | High when the block is the sync source |
| sync_err | output | 1 | One-clock flag for a misplaced or mis-sized sync pulse |
| first_bit | output | 1 | High on the first bit of the frame |
| frm_bit | output | 1 | High on the T1 framing bit |
| slot_idx | output | 5 | Current time-slot index |
| bit_idx | output | 3 | Current bit index inside the slot |
| dont_care | output | 1 | Current slot is unused in a T1-in-32-slot mapping |

## Verification
All eight modes are run, in both the source and follower roles, with clean sync patterns that start at a random phase. This separates the frame lengths and decode rules for each mode, and checks that alignment is taken from the rising edge. A deliberate stray pulse and a forward jump in the source phase tell a width or pattern error apart from a misplaced edge that forces realignment. Random single-clock flips add further cases. Two more runs cover other cases: one where sync_in is never driven, which must give no error before lock, and one where sync_in stops after lock, which must leave the counter free-running and flag every missed pulse.

// File: rtl/tdm_sync_pkg.sv
`timescale 1ns/1ps
package tdm_sync_pkg;
  localparam int POS_W  = 11;
  localparam int LEN_W  = POS_W + 1;
  localparam int SLOT_W = 5;
  localparam int BIT_W  = 3;

  typedef enum logic [2:0] {
    MD_T1_BASE = 3'd0,
    MD_E1_BASE = 3'd1,
    MD_HS2     = 3'd2,
    MD_HS4     = 3'd3,
    MD_HS8     = 3'd4,
    MD_HS16    = 3'd5,
    MD_WIDE4   = 3'd6,
    MD_WIDE2   = 3'd7
  } bp_mode_e;

  typedef enum logic [1:0] {PW_ONE, PW_FOUR, PW_TWO} pulse_e;

  function automatic logic [LEN_W-1:0] frame_len(bp_mode_e m);
    case (m)
      MD_T1_BASE:          return LEN_W'(193);
      MD_E1_BASE, MD_HS2:  return LEN_W'(256);
      MD_HS4:              return LEN_W'(512);
      MD_HS8, MD_WIDE2:    return LEN_W'(1024);
      default:             return LEN_W'(2048);
    endcase
  endfunction

  function automatic pulse_e pulse_kind(bp_mode_e m);
    case (m)
      MD_WIDE4: return PW_FOUR;
      MD_WIDE2: return PW_TWO;
      default:  return PW_ONE;
    endcase
  endfunction

  function automatic logic is_base(bp_mode_e m);
    return (m == MD_T1_BASE) || (m == MD_E1_BASE);
  endfunction

  // log2 of serial clocks per payload bit
  function automatic logic [1:0] rate_shift(bp_mode_e m);
    case (m)
      MD_HS4:            return 2'd1;
      MD_HS8, MD_WIDE2:  return 2'd2;
      MD_HS16, MD_WIDE4: return 2'd3;
      default:           return 2'd0;
    endcase
  endfunction

  // frame position marked by a rising edge of the sync input
  function automatic logic [POS_W-1:0] anchor_pos(bp_mode_e m);
    logic [LEN_W-1:0] len;
    len = frame_len(m);
    case (pulse_kind(m))
      PW_FOUR: return POS_W'(len - LEN_W'(2));
      PW_TWO:  return POS_W'(len - LEN_W'(1));
      default: return '0;
    endcase
  endfunction

  function automatic logic pulse_due(bp_mode_e m, logic [POS_W-1:0] p);
    logic [LEN_W-1:0] len;
    logic             at_last;
    len     = frame_len(m);
    at_last = ({1'b0, p} == len - LEN_W'(1));
    case (pulse_kind(m))
      PW_FOUR: return (p <= POS_W'(1)) || at_last || ({1'b0, p} == len - LEN_W'(2));
      PW_TWO:  return (p == '0) || at_last;
      default: return (p == '0);
    endcase
  endfunction
endpackage

// File: rtl/tdm_frame_counter.sv
`timescale 1ns/1ps
module tdm_frame_counter
  import tdm_sync_pkg::*;
#(
  parameter int PW = POS_W,
  parameter int LW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] len,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  output logic [PW-1:0] pos_q,
  output logic [PW-1:0] eff_pos,
  output logic          wrap
);
  logic [PW-1:0] pos_d;

  always_comb begin
    eff_pos = load ? load_val : pos_q;
    wrap    = ({1'b0, eff_pos} == len - LW'(1));
    pos_d   = wrap ? '0 : eff_pos + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end
endmodule

// File: rtl/tdm_sync_tracker.sv
`timescale 1ns/1ps
module tdm_sync_tracker
  import tdm_sync_pkg::*;
#(
  parameter int PW = POS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bp_mode_e      mode,
  input  logic          follow,
  input  logic          sync_in,
  input  logic [PW-1:0] pos_q,
  input  logic [PW-1:0] eff_pos,
  output logic          rise_evt,
  output logic          load,
  output logic [PW-1:0] anchor,
  output logic          locked,
  output logic          sync_err
);
  logic sync_q;
  logic misplaced;
  logic shape_bad;

  always_comb begin
    rise_evt  = follow && sync_in && !sync_q;
    load      = rise_evt;
    anchor    = PW'(anchor_pos(mode));
    misplaced = rise_evt && (pos_q != anchor);
    shape_bad = (sync_in != pulse_due(mode, POS_W'(eff_pos)));
    sync_err  = follow && locked && (misplaced || shape_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      locked <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (rise_evt) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_slot_decoder.sv
`timescale 1ns/1ps
module tdm_slot_decoder
  import tdm_sync_pkg::*;
#(
  parameter int PW = POS_W,
  parameter int SW = SLOT_W,
  parameter int BW = BIT_W
) (
  input  bp_mode_e      mode,
  input  logic          t1_map,
  input  logic [PW-1:0] eff_pos,
  output logic          first_bit,
  output logic          frm_bit,
  output logic [SW-1:0] slot_idx,
  output logic [BW-1:0] bit_idx,
  output logic          dont_care
);
  logic [PW-1:0] adj;
  logic [PW-1:0] scaled;

  always_comb begin
    adj       = eff_pos - PW'(1);
    scaled    = eff_pos >> rate_shift(mode);
    first_bit = (eff_pos == '0);
    if (mode == MD_T1_BASE) begin
      frm_bit  = first_bit;
      slot_idx = first_bit ? '0 : adj[BW +: SW];
      bit_idx  = first_bit ? '0 : adj[BW-1:0];
    end else begin
      frm_bit  = 1'b0;
      slot_idx = scaled[BW +: SW];
      bit_idx  = scaled[BW-1:0];
    end
    dont_care = t1_map && !is_base(mode) && (slot_idx[1:0] == 2'b00);
  end
endmodule

// File: rtl/tdm_rx_frame_timer.sv
`timescale 1ns/1ps
module tdm_rx_frame_timer
  import tdm_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              gen_req,
  input  logic              t1_map,
  input  logic              sync_in,
  output logic              sync_out,
  output logic              sync_drive,
  output logic              sync_err,
  output logic              first_bit,
  output logic              frm_bit,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              dont_care
);
  bp_mode_e         md;
  logic             gen_active;
  logic             follow;
  logic [LEN_W-1:0] frame_len_w;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] eff_pos;
  logic             wrap_evt;
  logic             rise_evt;
  logic             load_evt;
  logic [POS_W-1:0] anchor;
  logic             locked;

  assign md          = bp_mode_e'(mode);
  assign gen_active  = gen_req && is_base(md);
  assign follow      = !gen_active;
  assign frame_len_w = frame_len(md);

  tdm_frame_counter #(.PW(POS_W), .LW(LEN_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .len      (frame_len_w),
    .load     (load_evt),
    .load_val (anchor),
    .pos_q    (pos_q),
    .eff_pos  (eff_pos),
    .wrap     (wrap_evt)
  );

  tdm_sync_tracker #(.PW(POS_W)) i_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (md),
    .follow   (follow),
    .sync_in  (sync_in),
    .pos_q    (pos_q),
    .eff_pos  (eff_pos),
    .rise_evt (rise_evt),
    .load     (load_evt),
    .anchor   (anchor),
    .locked   (locked),
    .sync_err (sync_err)
  );

  tdm_slot_decoder #(.PW(POS_W), .SW(SLOT_W), .BW(BIT_W)) i_dec (
    .mode      (md),
    .t1_map    (t1_map),
    .eff_pos   (eff_pos),
    .first_bit (first_bit),
    .frm_bit   (frm_bit),
    .slot_idx  (slot_idx),
    .bit_idx   (bit_idx),
    .dont_care (dont_care)
  );

  assign sync_drive = gen_active;
  assign sync_out   = gen_active && rst_n && (eff_pos == '0);
endmodule

// File: rtl/tdm_rx_frame_timer_chk.sv
`timescale 1ns/1ps
module tdm_rx_frame_timer_chk
  import tdm_sync_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              sync_out,
  input logic              sync_drive,
  input logic              sync_err,
  input logic              first_bit,
  input logic [SLOT_W-1:0] slot_idx,
  input logic              dont_care,
  input logic [POS_W-1:0]  eff_pos,
  input logic [LEN_W-1:0]  frame_len_w,
  input logic              rise_evt,
  input logic              locked
);
  p_gen_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out);

  p_gen_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> first_bit);

  p_hs_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd2) |-> (!sync_drive && !sync_out));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, eff_pos} == frame_len_w - LEN_W'(1)) |=> (rise_evt || eff_pos == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, eff_pos} != frame_len_w - LEN_W'(1)) |=>
      (rise_evt || eff_pos == $past(eff_pos) + POS_W'(1)));

  p_t1_slots_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> (slot_idx < SLOT_W'(24)));

  p_dc_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode <= 3'd1) |-> !dont_care);

  p_follow_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && mode <= 3'd5) |-> first_bit);

  p_no_err_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !sync_err);
endmodule

bind tdm_rx_frame_timer tdm_rx_frame_timer_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .sync_out    (sync_out),
  .sync_drive  (sync_drive),
  .sync_err    (sync_err),
  .first_bit   (first_bit),
  .slot_idx    (slot_idx),
  .dont_care   (dont_care),
  .eff_pos     (eff_pos),
  .frame_len_w (frame_len_w),
  .rise_evt    (rise_evt),
  .locked      (locked)
);

// File: tb/test_tdm_rx_frame_timer.sv
`timescale 1ns/1ps
module test_tdm_rx_frame_timer;
  logic       clk;
  logic       rst_n;
  logic [2:0] mode;
  logic       gen_req;
  logic       t1_map;
  logic       sync_in;
  logic       sync_out, sync_drive, sync_err, first_bit, frm_bit, dont_care;
  logic [4:0] slot_idx;
  logic [2:0] bit_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int  mpos, cur_mode, cur_t1;
  bit  follower, m_locked, prev_s;

  tdm_rx_frame_timer i_tdm_rx_frame_timer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .gen_req(gen_req), .t1_map(t1_map),
    .sync_in(sync_in), .sync_out(sync_out), .sync_drive(sync_drive),
    .sync_err(sync_err), .first_bit(first_bit), .frm_bit(frm_bit),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .dont_care(dont_care)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int b_len(int m);
    int t [8] = '{193, 256, 256, 512, 1024, 2048, 2048, 1024};
    return t[m];
  endfunction

  function automatic int b_cpb(int m);
    return b_len(m) / 256;
  endfunction

  function automatic int b_slot(int m, int p);
    if (m == 0) return (p == 0) ? 0 : (p - 1) / 8;
    return p / (8 * b_cpb(m));
  endfunction

  function automatic int b_bit(int m, int p);
    if (m == 0) return (p == 0) ? 0 : (p - 1) % 8;
    return (p / b_cpb(m)) % 8;
  endfunction

  function automatic bit b_exp(int m, int p);
    int l = b_len(m);
    if (m == 6) return (p < 2) || (p >= l - 2);
    if (m == 7) return (p == 0) || (p == l - 1);
    return p == 0;
  endfunction

  function automatic int b_anchor(int m);
    if (m == 6) return b_len(m) - 2;
    if (m == 7) return b_len(m) - 1;
    return 0;
  endfunction

  function automatic bit b_dc(int m, int t1, int p);
    return (t1 != 0) && (m >= 2) && (b_slot(m, p) % 4 == 0);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit s);
    bit    rise;
    int    anc, eff;
    bit    xerr;
    string tg;
    sync_in = s;
    rise = follower && s && !prev_s;
    anc  = b_anchor(cur_mode);
    eff  = rise ? anc : mpos;
    xerr = follower && m_locked &&
           ((rise && mpos != anc) || (s != b_exp(cur_mode, eff)));
    #3;
    if (rise) tg = (m_locked && mpos != anc) ? "R10" : (cur_mode >= 6 ? "R8" : "R7");
    else      tg = (cur_mode == 0) ? "R4" : "R5";
    chk({tg, " slot"}, int'(slot_idx), b_slot(cur_mode, eff));
    chk({tg, " bit"}, int'(bit_idx), b_bit(cur_mode, eff));
    chk("R2 first_bit", int'(first_bit), int'(eff == 0));
    chk("R4 frm_bit", int'(frm_bit), int'(cur_mode == 0 && eff == 0));
    chk("R6 dont_care", int'(dont_care), int'(b_dc(cur_mode, cur_t1, eff)));
    chk("R3 sync_out", int'(sync_out), int'(!follower && eff == 0));
    chk("R3 sync_drive", int'(sync_drive), int'(!follower));
    chk("R9 sync_err", int'(sync_err), int'(xerr));
    if (rise) m_locked = 1'b1;
    prev_s = s;
    mpos = (eff + 1) % b_len(cur_mode);
    @(posedge clk); #1;
  endtask

  // kind 0: clean pattern with faults, 1: never driven, 2: stops after lock
  task automatic run_seg(input int m, input bit g, input bit t1, input int kind, input int nfr);
    int l, bpos, n;
    bit s;
    rst_n = 1'b0; mode = 3'(m); gen_req = g; t1_map = t1; sync_in = 1'b0;
    #3;
    chk("R1 reset slot", int'(slot_idx), 0);
    chk("R1 reset bit", int'(bit_idx), 0);
    chk("R1 reset first_bit", int'(first_bit), 1);
    chk("R1 reset sync_out", int'(sync_out), 0);
    chk("R1 reset sync_err", int'(sync_err), 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst_n = 1'b1;
    cur_mode = m; cur_t1 = t1;
    follower = !(g && m <= 1);
    mpos = 0; prev_s = 1'b0; m_locked = 1'b0;
    l = b_len(m);
    bpos = $urandom % l;
    n = nfr * l;
    for (int i = 0; i < n; i++) begin
      if (kind == 1 || (kind == 2 && i >= 2 * l)) s = 1'b0;
      else s = b_exp(m, bpos);
      if (follower && kind == 0) begin
        if (i == 2 * l + l / 2) s = !s;
        else if ($urandom % 3000 == 0) s = !s;
      end
      cycle(s);
      bpos = (bpos + 1) % l;
      if (i == 3 * l + 11) bpos = (bpos + 5) % l;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20517));
    rst_n = 1'b0; mode = 3'd0; gen_req = 1'b0; t1_map = 1'b0; sync_in = 1'b0;
    @(posedge clk); #1;
    run_seg(0, 1'b1, 1'b0, 0, 4);
    run_seg(1, 1'b1, 1'b1, 0, 4);
    run_seg(4, 1'b1, 1'b1, 0, 5);
    run_seg(2, 1'b0, 1'b0, 0, 6);
    run_seg(3, 1'b0, 1'b1, 0, 5);
    run_seg(5, 1'b0, 1'b0, 0, 5);
    run_seg(6, 1'b0, 1'b1, 0, 5);
    run_seg(7, 1'b0, 1'b0, 0, 5);
    run_seg(0, 1'b0, 1'b0, 0, 6);
    run_seg(1, 1'b0, 1'b0, 1, 3);
    run_seg(1, 1'b0, 1'b1, 2, 4);
    run_seg(6, 1'b0, 1'b0, 2, 3);
    finished = 1'b1;
    summary();
  end
endmodule